// File: doc/BRIEF.md
# USB OUT Endpoint Control Logic

This block holds the control and status state of a single USB device OUT endpoint and decides, for each token the protocol engine reports, which handshake goes back to the host. Software programs the endpoint through a one-cycle register write port. That port carries configuration fields and four write-one command bits, and a flat read word returns the live state. The protocol side reports SETUP tokens, OUT data packets, receive FIFO space, the global OUT NAK, the parity of the current frame, and the completion events for transfer, SETUP phase, disable and bus reset.

Each token gets a registered answer one cycle later: a 2-bit handshake code (00 none, 01 ACK, 10 NAK, 11 STALL) and a packet-accept strobe. Completion events clear the enable and disable bits on the same clock edge that raises the matching one-cycle interrupt pulse, so software never sees the interrupt while the bit is still set. NAK status and STALL are shared between software and hardware, each with a fixed rule for who may set and who may clear.

Top module: `usb_oep_ctrl`

## Requirements
- R1: After synchronous reset every field reads zero, the handshake output is 00 (none), and the accept strobe and all interrupt pulses are low.
- R2: A write loads max packet size into bits [10:0], active into bit 11, endpoint type into bits [13:12] (0 control, 1 isochronous, 2 bulk, 3 interrupt) and snoop into bit 14. The read word shows these fields at the same positions, STALL at 15, enable at 16, disable at 17, NAK status at 18 and frame parity at 19, all visible the cycle after the write.
- R3: Write bit 18 clears NAK status and write bit 19 sets it, with set winning when both are written. Hardware sets NAK status on a SETUP token and on transfer completion.
- R4: On a non-isochronous endpoint that is active and enabled and not stalled, an OUT packet is answered NAK without accept while NAK status or the global OUT NAK is set, even when the FIFO has room. Otherwise it gets ACK with accept when the FIFO has room, and NAK when it does not.
- R5: A SETUP token is always answered ACK with accept, whatever the NAK, STALL, active or enable state.
- R6: On a control, bulk or interrupt endpoint with STALL set, an OUT packet to an active, enabled endpoint is answered STALL without accept, overriding NAK status and the global OUT NAK.
- R7: STALL ownership depends on the endpoint type. On a control endpoint a write of 1 sets it, a write of 0 has no effect, and a SETUP token clears it. On bulk or interrupt endpoints a write loads it and hardware never clears it. On an isochronous endpoint writes to it are ignored.
- R8: Write bit 20 sets frame parity to 0 (even) and write bit 21 sets it to 1 (odd). An isochronous endpoint never returns a handshake and accepts an OUT packet only when the frame parity input matches the field, NAK status and global OUT NAK are clear, and the FIFO has room.
- R9: Writing disable has effect only while enable is already set. A disable acknowledge while disable is set clears both disable and enable and raises the endpoint-disabled interrupt one cycle later.
- R10: Writing 0 to enable has no effect. SETUP-phase-done and transfer-complete clear enable and raise their interrupt one cycle later, and enable reads zero whenever any interrupt pulse is high.
- R11: A USB reset clears the active bit, because the endpoint number parameter is not zero.
- R12: An OUT packet to an endpoint that is inactive or not enabled gets no handshake and no accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 22 | Write word: fields and command bits |
| rd_data | output | 20 | Read word: live endpoint state |
| setup_tok | input | 1 | SETUP data packet received |
| out_pkt | input | 1 | OUT data packet received |
| fifo_room | input | 1 | Receive FIFO can hold the packet |
| gnak_out | input | 1 | Global OUT NAK in force |
| frame_odd | input | 1 | Parity of the current frame number |
| setup_done | input | 1 | SETUP phase done event |
| xfer_done | input | 1 | Transfer complete event |
| dis_ack | input | 1 | Protocol engine has stopped the endpoint |
| usb_reset | input | 1 | USB bus reset detected |
| hs_code | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| pkt_accept | output | 1 | Packet is taken into the FIFO |
| int_setup_done | output | 1 | SETUP phase done interrupt pulse |
| int_xfer_done | output | 1 | Transfer complete interrupt pulse |
| int_disabled | output | 1 | Endpoint disabled interrupt pulse |

## Verification
The assertions assume every protocol input is synchronous to the clock and that token and event inputs are one-cycle pulses. They do not assume SETUP and OUT are mutually exclusive: each OUT-side property is guarded by the absence of a SETUP token, because SETUP takes priority. The bench follows this by changing every input on the falling edge and holding each pulse across exactly one rising edge. It restarts the endpoint with reset before each sweep case, so no state left over from one case can mask the outcome of the next.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

    localparam int MPS_W = 11;
    localparam int RD_W  = MPS_W + 9;
    localparam int WR_W  = MPS_W + 11;

    // field positions shared by read and write words
    localparam int B_ACT   = MPS_W;
    localparam int B_KIND  = MPS_W + 1;
    localparam int B_SNOOP = MPS_W + 3;
    localparam int B_STALL = MPS_W + 4;
    localparam int B_ENA   = MPS_W + 5;
    localparam int B_DIS   = MPS_W + 6;
    // read-only status positions
    localparam int B_NAK   = MPS_W + 7;
    localparam int B_ODD   = MPS_W + 8;
    // write-only command positions
    localparam int B_CNAK  = MPS_W + 7;
    localparam int B_SNAK  = MPS_W + 8;
    localparam int B_SEVEN = MPS_W + 9;
    localparam int B_SODD  = MPS_W + 10;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef struct packed {
        logic             odd;
        logic             nak;
        logic             dis;
        logic             ena;
        logic             stall;
        logic             snoop;
        ep_kind_e         kind;
        logic             active;
        logic [MPS_W-1:0] mps;
    } ep_state_t;

    function automatic logic [RD_W-1:0] pack_rd(input ep_state_t s);
        return {s.odd, s.nak, s.dis, s.ena, s.stall, s.snoop,
                s.kind, s.active, s.mps};
    endfunction

endpackage

// File: rtl/usb_oep_regs.sv
module usb_oep_regs
    import usb_oep_pkg::*;
#(
    parameter int EP_NUM = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            setup_tok,
    input  logic            setup_done,
    input  logic            xfer_done,
    input  logic            dis_ack,
    input  logic            usb_reset,
    output ep_state_t       st,
    output logic            int_setup_done,
    output logic            int_xfer_done,
    output logic            int_disabled
);

    ep_state_t nxt;

    always_comb begin
        nxt = st;
        if (wr_en) begin
            nxt.mps    = wr_data[MPS_W-1:0];
            nxt.active = wr_data[B_ACT];
            nxt.kind   = ep_kind_e'(wr_data[B_KIND+1:B_KIND]);
            nxt.snoop  = wr_data[B_SNOOP];
            unique case (st.kind)
                EP_CTRL: if (wr_data[B_STALL]) nxt.stall = 1'b1;
                EP_BULK,
                EP_INTR: nxt.stall = wr_data[B_STALL];
                EP_ISO:  nxt.stall = st.stall;
            endcase
            if (wr_data[B_ENA])           nxt.ena = 1'b1;
            if (wr_data[B_DIS] && st.ena) nxt.dis = 1'b1;
            if (wr_data[B_CNAK])          nxt.nak = 1'b0;
            if (wr_data[B_SNAK])          nxt.nak = 1'b1;
            if (wr_data[B_SEVEN])         nxt.odd = 1'b0;
            if (wr_data[B_SODD])          nxt.odd = 1'b1;
        end
        // hardware updates take precedence over software
        if (setup_tok) begin
            nxt.nak = 1'b1;
            if (st.kind == EP_CTRL) nxt.stall = 1'b0;
        end
        if (xfer_done) begin
            nxt.nak = 1'b1;
            nxt.ena = 1'b0;
        end
        if (setup_done) nxt.ena = 1'b0;
        if (dis_ack && st.dis) begin
            nxt.ena = 1'b0;
            nxt.dis = 1'b0;
        end
        if (usb_reset && (EP_NUM != 0)) nxt.active = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= '0;
            int_setup_done <= 1'b0;
            int_xfer_done  <= 1'b0;
            int_disabled   <= 1'b0;
        end else begin
            st             <= nxt;
            int_setup_done <= setup_done;
            int_xfer_done  <= xfer_done;
            int_disabled   <= dis_ack && st.dis;
        end
    end

    AST_NAK_HW_SET: assert property (@(posedge clk) disable iff (rst)
        (setup_tok || xfer_done) |=> st.nak); // R3

    AST_CTRL_STALL_CLR: assert property (@(posedge clk) disable iff (rst)
        (setup_tok && st.kind == EP_CTRL) |=> !st.stall); // R7

    AST_DIS_NEEDS_ENA: assert property (@(posedge clk) disable iff (rst)
        $rose(st.dis) |-> $past(st.ena)); // R9

    AST_INT_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
        (int_setup_done || int_xfer_done || int_disabled) |-> !st.ena); // R10

    generate
        if (EP_NUM != 0) begin : g_bus_reset_chk
            AST_BUS_RST_INACTIVE: assert property (@(posedge clk) disable iff (rst)
                usb_reset |=> !st.active); // R11
        end
    endgenerate

endmodule

// File: rtl/usb_oep_resp.sv
module usb_oep_resp
    import usb_oep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     ena,
    input  logic     nak,
    input  logic     stall,
    input  logic     odd,
    input  ep_kind_e kind,
    input  logic     setup_tok,
    input  logic     out_pkt,
    input  logic     fifo_room,
    input  logic     gnak_out,
    input  logic     frame_odd,
    output hs_code_e hs,
    output logic     accept
);

    hs_code_e hs_d;
    logic     acc_d;
    logic     live;
    logic     blocked;

    assign live    = active && ena;
    assign blocked = nak || gnak_out;

    always_comb begin
        hs_d  = HS_NONE;
        acc_d = 1'b0;
        if (setup_tok) begin
            hs_d  = HS_ACK;
            acc_d = 1'b1;
        end else if (out_pkt && live) begin
            if (kind == EP_ISO) begin
                acc_d = (frame_odd == odd) && !blocked && fifo_room;
            end else if (stall) begin
                hs_d = HS_STALL;
            end else if (blocked || !fifo_room) begin
                hs_d = HS_NAK;
            end else begin
                hs_d  = HS_ACK;
                acc_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs     <= HS_NONE;
            accept <= 1'b0;
        end else begin
            hs     <= hs_d;
            accept <= acc_d;
        end
    end

    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (rst)
        setup_tok |=> (hs == HS_ACK && accept)); // R5

    AST_STALL_WINS: assert property (@(posedge clk) disable iff (rst)
        (out_pkt && !setup_tok && live && stall && kind != EP_ISO)
        |=> (hs == HS_STALL && !accept)); // R6

    AST_NAK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_pkt && !setup_tok && blocked) |=> !accept); // R4

    AST_ISO_PARITY: assert property (@(posedge clk) disable iff (rst)
        (out_pkt && !setup_tok && kind == EP_ISO && frame_odd != odd)
        |=> (!accept && hs == HS_NONE)); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (out_pkt && !setup_tok && !live) |=> (hs == HS_NONE && !accept)); // R12

endmodule

// File: rtl/usb_oep_ctrl.sv
module usb_oep_ctrl
    import usb_oep_pkg::*;
#(
    parameter int EP_NUM = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic [RD_W-1:0] rd_data,
    input  logic            setup_tok,
    input  logic            out_pkt,
    input  logic            fifo_room,
    input  logic            gnak_out,
    input  logic            frame_odd,
    input  logic            setup_done,
    input  logic            xfer_done,
    input  logic            dis_ack,
    input  logic            usb_reset,
    output logic [1:0]      hs_code,
    output logic            pkt_accept,
    output logic            int_setup_done,
    output logic            int_xfer_done,
    output logic            int_disabled
);

    ep_state_t st;
    hs_code_e  hs;

    usb_oep_regs #(.EP_NUM(EP_NUM)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .setup_tok      (setup_tok),
        .setup_done     (setup_done),
        .xfer_done      (xfer_done),
        .dis_ack        (dis_ack),
        .usb_reset      (usb_reset),
        .st             (st),
        .int_setup_done (int_setup_done),
        .int_xfer_done  (int_xfer_done),
        .int_disabled   (int_disabled)
    );

    usb_oep_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .active    (st.active),
        .ena       (st.ena),
        .nak       (st.nak),
        .stall     (st.stall),
        .odd       (st.odd),
        .kind      (st.kind),
        .setup_tok (setup_tok),
        .out_pkt   (out_pkt),
        .fifo_room (fifo_room),
        .gnak_out  (gnak_out),
        .frame_odd (frame_odd),
        .hs        (hs),
        .accept    (pkt_accept)
    );

    assign rd_data = pack_rd(st);
    assign hs_code = hs;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && hs_code == 2'b00 && !pkt_accept)); // R1

endmodule

// File: tb/usb_oep_ctrl_bench.sv
`timescale 1ns/1ps
module usb_oep_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [21:0] wr_data = '0;
    logic [19:0] rd_data;
    logic        setup_tok = 0, out_pkt = 0, fifo_room = 0, gnak_out = 0;
    logic        frame_odd = 0, setup_done = 0, xfer_done = 0, dis_ack = 0;
    logic        usb_reset = 0;
    logic [1:0]  hs_code;
    logic        pkt_accept, int_setup_done, int_xfer_done, int_disabled;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    usb_oep_ctrl u_usb_oep_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .setup_tok(setup_tok), .out_pkt(out_pkt),
        .fifo_room(fifo_room), .gnak_out(gnak_out), .frame_odd(frame_odd),
        .setup_done(setup_done), .xfer_done(xfer_done), .dis_ack(dis_ack),
        .usb_reset(usb_reset), .hs_code(hs_code), .pkt_accept(pkt_accept),
        .int_setup_done(int_setup_done), .int_xfer_done(int_xfer_done),
        .int_disabled(int_disabled)
    );

    // write-word command bits
    localparam logic [21:0] C_CNAK = 22'h1 << 18;
    localparam logic [21:0] C_SNAK = 22'h1 << 19;
    localparam logic [21:0] C_SEVN = 22'h1 << 20;
    localparam logic [21:0] C_SODD = 22'h1 << 21;

    // event bits for drive_ev
    localparam int E_SETUP = 0, E_OUT = 1, E_ROOM = 2, E_GNAK = 3, E_FODD = 4;
    localparam int E_SDONE = 5, E_XDONE = 6, E_DACK = 7, E_BRST = 8;

    function automatic logic [21:0] cfg(input int mps, input bit act,
            input int kind, input bit snp, input bit stl, input bit ena, input bit dis);
        logic [21:0] w;
        w        = '0;
        w[10:0]  = mps[10:0];
        w[11]    = act;
        w[13:12] = kind[1:0];
        w[14]    = snp;
        w[15]    = stl;
        w[16]    = ena;
        w[17]    = dis;
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [21:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic drive_ev(input logic [8:0] ev);
        @(negedge clk);
        setup_tok = ev[E_SETUP]; out_pkt = ev[E_OUT]; fifo_room = ev[E_ROOM];
        gnak_out = ev[E_GNAK]; frame_odd = ev[E_FODD]; setup_done = ev[E_SDONE];
        xfer_done = ev[E_XDONE]; dis_ack = ev[E_DACK]; usb_reset = ev[E_BRST];
        @(negedge clk);
        setup_tok = 0; out_pkt = 0; fifo_room = 0; gnak_out = 0; frame_odd = 0;
        setup_done = 0; xfer_done = 0; dis_ack = 0; usb_reset = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] ev;
        int exp_hs, exp_acc;
        string req;

        do_reset();
        check("R1 read word", int'(rd_data), 0);
        check("R1 handshake", int'(hs_code), 0);
        check("R1 accept", int'(pkt_accept), 0);
        check("R1 interrupts", int'({int_setup_done, int_xfer_done, int_disabled}), 0);

        // R2 field layout
        wr(cfg(11'h5A5, 1, 2, 1, 0, 0, 0));
        check("R2 readback", int'(rd_data), int'(cfg(11'h5A5, 1, 2, 1, 0, 0, 0)));

        // R3 NAK commands
        wr(cfg(11'h5A5, 1, 2, 1, 0, 0, 0) | C_SNAK);
        check("R3 set-NAK", int'(rd_data[18]), 1);
        wr(cfg(11'h5A5, 1, 2, 1, 0, 0, 0) | C_CNAK);
        check("R3 clear-NAK", int'(rd_data[18]), 0);
        wr(cfg(11'h5A5, 1, 2, 1, 0, 0, 0) | C_CNAK | C_SNAK);
        check("R3 set wins", int'(rd_data[18]), 1);

        // R5 SETUP on stalled, NAKed, inactive bulk endpoint; R7 bulk keeps STALL
        wr(cfg(64, 0, 2, 0, 1, 0, 0));
        ev = '0; ev[E_SETUP] = 1; drive_ev(ev);
        check("R5 SETUP handshake", int'(hs_code), 1);
        check("R5 SETUP accept", int'(pkt_accept), 1);
        check("R3 SETUP sets NAK", int'(rd_data[18]), 1);
        check("R7 bulk STALL kept after SETUP", int'(rd_data[15]), 1);
        wr(cfg(64, 0, 2, 0, 0, 0, 0));
        check("R7 bulk STALL cleared by write", int'(rd_data[15]), 0);

        // R7 control endpoint
        do_reset();
        wr(cfg(64, 1, 0, 0, 1, 0, 0));
        check("R7 control STALL set", int'(rd_data[15]), 1);
        wr(cfg(64, 1, 0, 0, 0, 0, 0));
        check("R7 control STALL write 0 ignored", int'(rd_data[15]), 1);
        ev = '0; ev[E_SETUP] = 1; drive_ev(ev);
        check("R7 control STALL cleared by SETUP", int'(rd_data[15]), 0);

        // R7 isochronous endpoint ignores STALL writes
        do_reset();
        wr(cfg(64, 1, 1, 0, 0, 0, 0));
        wr(cfg(64, 1, 1, 0, 1, 0, 0));
        check("R7 iso STALL write ignored", int'(rd_data[15]), 0);

        // R9 disable guard and acknowledge
        do_reset();
        wr(cfg(64, 1, 2, 0, 0, 0, 1));
        check("R9 disable without enable", int'(rd_data[17]), 0);
        wr(cfg(64, 1, 2, 0, 0, 1, 0));
        wr(cfg(64, 1, 2, 0, 0, 1, 1));
        check("R9 disable with enable", int'(rd_data[17]), 1);
        ev = '0; ev[E_DACK] = 1; drive_ev(ev);
        check("R9 disabled interrupt", int'(int_disabled), 1);
        check("R9 enable and disable cleared", int'(rd_data[17:16]), 0);

        // R10 enable ownership
        do_reset();
        wr(cfg(64, 1, 2, 0, 0, 1, 0));
        wr(cfg(64, 1, 2, 0, 0, 0, 0));
        check("R10 enable write 0 ignored", int'(rd_data[16]), 1);
        ev = '0; ev[E_XDONE] = 1; drive_ev(ev);
        check("R10 transfer interrupt", int'(int_xfer_done), 1);
        check("R10 enable cleared by transfer", int'(rd_data[16]), 0);
        check("R3 transfer sets NAK", int'(rd_data[18]), 1);
        wr(cfg(64, 1, 2, 0, 0, 1, 0));
        ev = '0; ev[E_SDONE] = 1; drive_ev(ev);
        check("R10 SETUP-done interrupt", int'(int_setup_done), 1);
        check("R10 enable cleared by SETUP-done", int'(rd_data[16]), 0);

        // R11 bus reset
        wr(cfg(64, 1, 2, 0, 0, 0, 0));
        ev = '0; ev[E_BRST] = 1; drive_ev(ev);
        check("R11 active cleared", int'(rd_data[11]), 0);

        // R12 inactive or disabled endpoints stay silent
        do_reset();
        wr(cfg(64, 1, 2, 0, 0, 0, 0));
        ev = '0; ev[E_OUT] = 1; ev[E_ROOM] = 1; drive_ev(ev);
        check("R12 not enabled handshake", int'(hs_code), 0);
        check("R12 not enabled accept", int'(pkt_accept), 0);
        wr(cfg(64, 0, 2, 0, 0, 1, 0));
        ev = '0; ev[E_OUT] = 1; ev[E_ROOM] = 1; drive_ev(ev);
        check("R12 inactive handshake", int'(hs_code), 0);
        check("R12 inactive accept", int'(pkt_accept), 0);

        // R8 parity commands
        wr(cfg(64, 1, 1, 0, 0, 0, 0) | C_SODD);
        check("R8 odd command", int'(rd_data[19]), 1);
        wr(cfg(64, 1, 1, 0, 0, 0, 0) | C_SEVN);
        check("R8 even command", int'(rd_data[19]), 0);

        // sweep: type x stall x NAK x global NAK x room x parity x frame
        for (int k = 0; k < 4; k++)
        for (int s = 0; s < 2; s++)
        for (int n = 0; n < 2; n++)
        for (int g = 0; g < 2; g++)
        for (int r = 0; r < 2; r++)
        for (int p = 0; p < 2; p++)
        for (int f = 0; f < 2; f++) begin
            do_reset();
            wr(cfg(64, 1, k, 0, 0, 0, 0));
            wr(cfg(64, 1, k, 0, s[0], 1, 0) | (p != 0 ? C_SODD : C_SEVN)
               | (n != 0 ? C_SNAK : 22'h0));
            ev = '0; ev[E_OUT] = 1; ev[E_ROOM] = r[0]; ev[E_GNAK] = g[0];
            ev[E_FODD] = f[0];
            drive_ev(ev);
            if (k == 1) begin
                req = "R8";
                exp_hs = 0;
                exp_acc = (p == f && n == 0 && g == 0 && r == 1) ? 1 : 0;
            end else if (s == 1) begin
                req = "R6";
                exp_hs = 3; exp_acc = 0;
            end else begin
                req = "R4";
                if (n == 1 || g == 1 || r == 0) begin exp_hs = 2; exp_acc = 0; end
                else begin exp_hs = 1; exp_acc = 1; end
            end
            check($sformatf("%s sweep hs k%0d s%0d n%0d g%0d r%0d p%0d f%0d",
                  req, k, s, n, g, r, p, f), int'(hs_code), exp_hs);
            check($sformatf("%s sweep acc k%0d s%0d n%0d g%0d r%0d p%0d f%0d",
                  req, k, s, n, g, r, p, f), int'(pkt_accept), exp_acc);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule